// File: doc/BRIEF.md
# External Bus Sizer and Strobe Generator

This block sits between a CPU's access port and an external static-memory bus. It takes one access request at a time, made up of a 24-bit byte address, a byte or word size, a direction and write data. It decides whether the address falls into on-chip ROM or RAM. Internal accesses complete at once and never touch the external pins. External accesses are turned into one or two bus cycles, each with an active-low address strobe, a read strobe and per-lane write strobes. Data is placed on the correct byte lane.

The external bus is either 16 or 8 bits wide. On the narrow bus only the upper lane is wired, so a word is moved as two byte cycles: the even byte first, then the odd byte. A one-cycle idle gap separates the two cycles, and the two read bytes are joined back into one word. The length of each bus cycle belongs to a separate cycle sequencer. This block raises `cyc_req_o` and holds its strobes until the sequencer answers with `cyc_ack_i`.

Top module: `ext_bus_sizer`

## Requirements
- R1: After reset, and at any time no external access is in progress, `as_no`, `rd_no`, `hwr_no` and `lwr_no` are high, `cyc_req_o` and `busy_o` are low.
- R2: With ROM enabled, addresses 0x000000..0x01FFFF are internal. With RAM enabled, addresses 0xFFDF10..0xFFFF0F are internal. An internal access pulses `done_o` and `internal_o` for one cycle in the cycle after acceptance, and it drives no strobe and no `cyc_req_o`. The first address past either range is external.
- R3: With `single_chip_i` high, every access is internal and handled as in R2, whatever its address.
- R4: With `bus16_i` low (8-bit bus), each cycle uses the upper lane `dout_o[15:8]` / `din_i[15:8]`. Writes use `hwr_no`. `lwr_no` stays high and `dout_o[7:0]` stays zero. A byte read returns the byte in `rdata_o[7:0]`, with the upper byte zero.
- R5: A word access on the 8-bit bus runs as two cycles. The first uses the even address with `wdata_i[15:8]`. Then comes a one-cycle gap with all strobes high. The second uses address | 1 with `wdata_i[7:0]`. The read result is first byte in `rdata_o[15:8]` and second byte in `rdata_o[7:0]`.
- R6: On the 16-bit bus a byte access to an even address uses the upper lane and `hwr_no`. A byte access to an odd address uses the lower lane and `lwr_no`. Write data is taken from `wdata_i[7:0]`. Read data returns in `rdata_o[7:0]`.
- R7: On the 16-bit bus a word access is one cycle. A write drives `dout_o = wdata_i` with both `hwr_no` and `lwr_no` low. A read returns `din_i` unchanged.
- R8: A word access to an odd address pulses `align_err_o` for one cycle, starts no bus cycle and produces no `done_o`. This check takes priority over the internal decode.
- R9: `busy_o` stays high from acceptance until the final acknowledge. Requests arriving in that time are ignored. The address and strobes stay stable while the sequencer withholds `cyc_ack_i`. `done_o` pulses once in the cycle after the final acknowledge.
- R10: During a cycle `as_no` is low. `rd_no` is low only for reads. Write strobes and `dout_en_o` are active only for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when not busy |
| addr_i | input | 24 | Byte address |
| word_i | input | 1 | 1 = word, 0 = byte |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data; bytes in [7:0] |
| bus16_i | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| irom_en_i | input | 1 | On-chip ROM mapped |
| iram_en_i | input | 1 | On-chip RAM mapped |
| single_chip_i | input | 1 | All space internal |
| busy_o | output | 1 | External access in progress |
| done_o | output | 1 | Access finished (one-cycle pulse) |
| internal_o | output | 1 | Finished access was internal |
| align_err_o | output | 1 | Odd word address rejected (pulse) |
| rdata_o | output | 16 | Assembled read data |
| cyc_req_o | output | 1 | Bus cycle request to sequencer |
| cyc_ack_i | input | 1 | Sequencer ends current cycle |
| ext_addr_o | output | 24 | External address |
| as_no | output | 1 | Address strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| hwr_no | output | 1 | Upper-lane write strobe, active low |
| lwr_no | output | 1 | Lower-lane write strobe, active low |
| dout_o | output | 16 | Write data on byte lanes |
| dout_en_o | output | 1 | Data bus drive enable |
| din_i | input | 16 | Read data from bus |

## Verification
The hardest state to reach is the middle of a split word access. The first byte is already captured, the gap cycle is running, and a new CPU request may arrive. The stimulus drives `cyc_ack_i` itself, one cycle at a time, so it can stop in the gap to check the idle strobes. It then checks that the second cycle carries the odd address and the low write byte. Separately, it withholds the acknowledge for several cycles and raises a competing request meanwhile, to show that the address holds and that the request is dropped.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_GAP  = 2'd2
  } ebs_state_e;

  typedef struct packed {
    logic as_n;
    logic rd_n;
    logic hwr_n;
    logic lwr_n;
  } ebs_strb_t;
endpackage

// File: rtl/ebs_addr_decode.sv
module ebs_addr_decode #(
  parameter int            AW      = 24,
  parameter logic [AW-1:0] IROM_HI = 24'h01FFFF,
  parameter logic [AW-1:0] IRAM_LO = 24'hFFDF10,
  parameter logic [AW-1:0] IRAM_HI = 24'hFFFF0F
) (
  input  logic [AW-1:0] addr_i,
  input  logic          irom_en_i,
  input  logic          iram_en_i,
  input  logic          single_chip_i,
  output logic          internal_o
);
  logic rom_hit, ram_hit;

  assign rom_hit = irom_en_i && (addr_i <= IROM_HI);

  // RAM window is optional: an empty range (HI < LO) removes the compare
  generate
    if (IRAM_HI >= IRAM_LO) begin : g_ram
      assign ram_hit = iram_en_i && (addr_i >= IRAM_LO) && (addr_i <= IRAM_HI);
    end else begin : g_no_ram
      assign ram_hit = 1'b0;
    end
  endgenerate

  assign internal_o = single_chip_i || rom_hit || ram_hit;
endmodule

// File: rtl/ebs_lane_steer.sv
module ebs_lane_steer #(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic            act_i,
  input  logic            phase_i,
  input  logic            addr0_i,
  input  logic            word_i,
  input  logic            write_i,
  input  logic            bus16_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   din_i,
  input  logic [DW-1:0]   rdata_i,
  output ebs_pkg::ebs_strb_t strb_o,
  output logic [DW-1:0]   dout_o,
  output logic            dout_en_o,
  output logic            addr0_o,
  output logic [DW-1:0]   rdata_nxt_o
);
  logic lane_hi, lane_lo;
  logic [BW-1:0] wr_byte;

  assign lane_hi = !bus16_i || word_i || !addr0_i;
  assign lane_lo = bus16_i && (word_i || addr0_i);

  assign strb_o.as_n  = !act_i;
  assign strb_o.rd_n  = !(act_i && !write_i);
  assign strb_o.hwr_n = !(act_i && write_i && lane_hi);
  assign strb_o.lwr_n = !(act_i && write_i && lane_lo);
  assign dout_en_o    = act_i && write_i;
  assign addr0_o      = phase_i ? 1'b1 : addr0_i;

  // narrow word: even byte (upper half) goes out first
  assign wr_byte = (word_i && !phase_i) ? wdata_i[DW-1:BW] : wdata_i[BW-1:0];

  always_comb begin
    if (!bus16_i)          dout_o = {wr_byte, {BW{1'b0}}};
    else if (word_i)       dout_o = wdata_i;
    else if (!addr0_i)     dout_o = {wdata_i[BW-1:0], {BW{1'b0}}};
    else                   dout_o = {{BW{1'b0}}, wdata_i[BW-1:0]};
  end

  always_comb begin
    if (!bus16_i) begin
      if (!word_i)         rdata_nxt_o = {{BW{1'b0}}, din_i[DW-1:BW]};
      else if (!phase_i)   rdata_nxt_o = {din_i[DW-1:BW], rdata_i[BW-1:0]};
      else                 rdata_nxt_o = {rdata_i[DW-1:BW], din_i[DW-1:BW]};
    end else begin
      if (word_i)          rdata_nxt_o = din_i;
      else if (!addr0_i)   rdata_nxt_o = {{BW{1'b0}}, din_i[DW-1:BW]};
      else                 rdata_nxt_o = {{BW{1'b0}}, din_i[BW-1:0]};
    end
  end
endmodule

// File: rtl/ebs_seq_ctrl.sv
module ebs_seq_ctrl #(
  parameter int AW = 24,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          word_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bus16_i,
  input  logic          internal_i,
  input  logic          cyc_ack_i,
  input  logic [DW-1:0] rdata_nxt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          internal_o,
  output logic          align_err_o,
  output logic          act_o,
  output logic          phase_o,
  output logic [AW-1:0] addr_o,
  output logic          word_o,
  output logic          write_o,
  output logic [DW-1:0] wdata_o,
  output logic          bus16_o,
  output logic [DW-1:0] rdata_o
);
  import ebs_pkg::*;

  ebs_state_e state_q;
  logic split;

  assign split  = word_o && !bus16_o;
  assign busy_o = (state_q != ST_IDLE);
  assign act_o  = (state_q == ST_BUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_o     <= 1'b0;
      done_o      <= 1'b0;
      internal_o  <= 1'b0;
      align_err_o <= 1'b0;
      addr_o      <= '0;
      word_o      <= 1'b0;
      write_o     <= 1'b0;
      wdata_o     <= '0;
      bus16_o     <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o      <= 1'b0;
      internal_o  <= 1'b0;
      align_err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (word_i && addr_i[0]) begin
            align_err_o <= 1'b1;
          end else if (internal_i) begin
            done_o     <= 1'b1;
            internal_o <= 1'b1;
          end else begin
            state_q <= ST_BUS;
            phase_o <= 1'b0;
            addr_o  <= addr_i;
            word_o  <= word_i;
            write_o <= write_i;
            wdata_o <= wdata_i;
            bus16_o <= bus16_i;
          end
        end
        ST_BUS: if (cyc_ack_i) begin
          if (!write_o) rdata_o <= rdata_nxt_i;
          if (split && !phase_o) begin
            state_q <= ST_GAP;
          end else begin
            state_q <= ST_IDLE;
            phase_o <= 1'b0;
            done_o  <= 1'b1;
          end
        end
        ST_GAP: begin
          state_q <= ST_BUS;
          phase_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r8_err_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !busy_o && !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r2_internal_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    internal_o |-> done_o);
  a_r5_gap_then_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> act_o && phase_o);
endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer #(
  parameter int            AW      = 24,
  parameter int            BW      = 8,
  parameter logic [AW-1:0] IROM_HI = 24'h01FFFF,
  parameter logic [AW-1:0] IRAM_LO = 24'hFFDF10,
  parameter logic [AW-1:0] IRAM_HI = 24'hFFFF0F,
  localparam int           DW      = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          word_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bus16_i,
  input  logic          irom_en_i,
  input  logic          iram_en_i,
  input  logic          single_chip_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          internal_o,
  output logic          align_err_o,
  output logic [DW-1:0] rdata_o,
  output logic          cyc_req_o,
  input  logic          cyc_ack_i,
  output logic [AW-1:0] ext_addr_o,
  output logic          as_no,
  output logic          rd_no,
  output logic          hwr_no,
  output logic          lwr_no,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  input  logic [DW-1:0] din_i
);
  import ebs_pkg::*;

  logic          is_int, act, phase, word_q, write_q, bus16_q, addr0;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_nxt;
  ebs_strb_t     strb;

  ebs_addr_decode #(
    .AW(AW), .IROM_HI(IROM_HI), .IRAM_LO(IRAM_LO), .IRAM_HI(IRAM_HI)
  ) u_dec (
    .addr_i        (addr_i),
    .irom_en_i     (irom_en_i),
    .iram_en_i     (iram_en_i),
    .single_chip_i (single_chip_i),
    .internal_o    (is_int)
  );

  ebs_seq_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .word_i      (word_i),
    .write_i     (write_i),
    .wdata_i     (wdata_i),
    .bus16_i     (bus16_i),
    .internal_i  (is_int),
    .cyc_ack_i   (cyc_ack_i),
    .rdata_nxt_i (rdata_nxt),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .internal_o  (internal_o),
    .align_err_o (align_err_o),
    .act_o       (act),
    .phase_o     (phase),
    .addr_o      (addr_q),
    .word_o      (word_q),
    .write_o     (write_q),
    .wdata_o     (wdata_q),
    .bus16_o     (bus16_q),
    .rdata_o     (rdata_o)
  );

  ebs_lane_steer #(.BW(BW)) u_steer (
    .act_i       (act),
    .phase_i     (phase),
    .addr0_i     (addr_q[0]),
    .word_i      (word_q),
    .write_i     (write_q),
    .bus16_i     (bus16_q),
    .wdata_i     (wdata_q),
    .din_i       (din_i),
    .rdata_i     (rdata_o),
    .strb_o      (strb),
    .dout_o      (dout_o),
    .dout_en_o   (dout_en_o),
    .addr0_o     (addr0),
    .rdata_nxt_o (rdata_nxt)
  );

  assign cyc_req_o  = act;
  assign ext_addr_o = {addr_q[AW-1:1], addr0};
  assign as_no      = strb.as_n;
  assign rd_no      = strb.rd_n;
  assign hwr_no     = strb.hwr_n;
  assign lwr_no     = strb.lwr_n;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> as_no && rd_no && hwr_no && lwr_no && !cyc_req_o);
  a_r4_narrow_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_req_o && !bus16_q) |-> lwr_no && (dout_o[BW-1:0] == '0));
  a_r10_rd_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> hwr_no && lwr_no && !dout_en_o && !as_no);
  a_r5_second_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_req_o && phase) |-> ext_addr_o[0]);
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_req_o && $past(cyc_req_o) && !$past(cyc_ack_i)) |-> $stable(ext_addr_o) && $stable(dout_o));
endmodule

// File: tb/ext_bus_sizer_test.sv
module ext_bus_sizer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] addr;
    logic        word;
    logic        write;
    logic [15:0] wdata;
    logic        bus16;
    logic        irom;
    logic        iram;
    logic        sc;
    logic [15:0] din0;
    logic [15:0] din1;
    logic [1:0]  kind;   // 0 internal, 1 external, 2 align error
    logic [3:0]  strb;   // {as,rd,hwr,lwr}
    logic [15:0] dout0;
    logic [15:0] dout1;
    logic [15:0] rdata;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{24'h020000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA53C, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h00A5},
    '{24'h020001, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7E11, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h007E},
    '{24'h100000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1299, 16'h3400, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h1234},
    '{24'h100002, 1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd1, 4'b0101, 16'hBE00, 16'hEF00, 16'h0000},
    '{24'h200003, 1'b0, 1'b1, 16'h0055, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'd1, 4'b0101, 16'h5500, 16'h0000, 16'h0000},
    '{24'h300000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'hCAFE, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'hCAFE},
    '{24'h300010, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h9A1B, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h009A},
    '{24'h300011, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h9A1B, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h001B},
    '{24'h300020, 1'b1, 1'b1, 16'h1357, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd1, 4'b0100, 16'h1357, 16'h0000, 16'h0000},
    '{24'h300022, 1'b0, 1'b1, 16'h00C3, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd1, 4'b0101, 16'hC300, 16'h0000, 16'h0000},
    '{24'h300023, 1'b0, 1'b1, 16'h00C3, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd1, 4'b0110, 16'h00C3, 16'h0000, 16'h0000},
    '{24'h01FFFF, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'd0, 4'b1111, 16'h0000, 16'h0000, 16'h0000},
    '{24'h01FFFE, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0F0F, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h0F0F},
    '{24'hFFDF10, 1'b0, 1'b1, 16'h0011, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd0, 4'b1111, 16'h0000, 16'h0000, 16'h0000},
    '{24'hFFFF10, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h6600, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h0066},
    '{24'hFFDF0F, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0077, 16'h0000, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'h0077},
    '{24'h800000, 1'b1, 1'b1, 16'h4242, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 2'd0, 4'b1111, 16'h0000, 16'h0000, 16'h0000},
    '{24'h100001, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd2, 4'b1111, 16'h0000, 16'h0000, 16'h0000},
    '{24'h000003, 1'b1, 1'b1, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'd2, 4'b1111, 16'h0000, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, word = 1'b0, write = 1'b0, bus16 = 1'b0;
  logic irom = 1'b0, iram = 1'b0, sc = 1'b0, ack = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, din = '0;
  logic busy, done, internal, aerr, cyc_req, as_n, rd_n, hwr_n, lwr_n, dout_en;
  logic [15:0] rdata, dout;
  logic [23:0] ext_addr;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_sizer uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .word_i(word),
    .write_i(write), .wdata_i(wdata), .bus16_i(bus16), .irom_en_i(irom),
    .iram_en_i(iram), .single_chip_i(sc), .busy_o(busy), .done_o(done),
    .internal_o(internal), .align_err_o(aerr), .rdata_o(rdata),
    .cyc_req_o(cyc_req), .cyc_ack_i(ack), .ext_addr_o(ext_addr),
    .as_no(as_n), .rd_no(rd_n), .hwr_no(hwr_n), .lwr_no(lwr_n),
    .dout_o(dout), .dout_en_o(dout_en), .din_i(din)
  );

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req_tag, what, got, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {as_n, rd_n, hwr_n, lwr_n};
  endfunction

  task automatic run_vec(input vec_t v);
    string tag;
    logic split;
    split = v.word && !v.bus16;
    if (v.kind == 2'd2)      tag = "R8";
    else if (v.kind == 2'd0) tag = v.sc ? "R3" : "R2";
    else if (split)          tag = "R5";
    else if (!v.bus16)       tag = "R4";
    else if (v.word)         tag = "R7";
    else                     tag = "R6";
    @(negedge clk);
    addr = v.addr; word = v.word; write = v.write; wdata = v.wdata;
    bus16 = v.bus16; irom = v.irom; iram = v.iram; sc = v.sc; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (v.kind == 2'd2) begin
      chk(tag, "align_err", aerr, 1);
      chk(tag, "busy", busy, 0);
      chk(tag, "strobes", strobes(), 4'hF);
      chk(tag, "done", done, 0);
      @(negedge clk);
      chk(tag, "align_err pulse end", aerr, 0);
      chk(tag, "no cycle", cyc_req, 0);
    end else if (v.kind == 2'd0) begin
      chk(tag, "done", done, 1);
      chk(tag, "internal", internal, 1);
      chk(tag, "strobes", strobes(), 4'hF);
      chk(tag, "cyc_req", cyc_req, 0);
      chk(tag, "busy", busy, 0);
    end else begin
      chk(tag, "busy", busy, 1);
      chk(tag, "cyc_req", cyc_req, 1);
      chk("R10", "strobes ph0", strobes(), v.strb);
      chk(tag, "addr ph0", ext_addr, v.addr);
      chk("R10", "dout_en", dout_en, v.write);
      if (v.write) chk(tag, "dout ph0", dout, v.dout0);
      din = v.din0; ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      if (split) begin
        chk("R5", "gap strobes", strobes(), 4'hF);
        chk("R5", "gap busy", busy, 1);
        @(negedge clk);
        chk("R10", "strobes ph1", strobes(), v.strb);
        chk("R5", "addr ph1", ext_addr, v.addr | 24'h1);
        if (v.write) chk("R5", "dout ph1", dout, v.dout1);
        din = v.din1; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
      chk("R9", "done", done, 1);
      chk("R9", "busy end", busy, 0);
      chk(tag, "internal", internal, 0);
      chk("R1", "strobes end", strobes(), 4'hF);
      if (!v.write) chk(tag, "rdata", rdata, v.rdata);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset strobes", strobes(), 4'hF);
    chk("R1", "reset busy", busy, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "idle strobes", strobes(), 4'hF);
    chk("R1", "idle cyc_req", cyc_req, 0);
    chk("R1", "idle done", done, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: withheld ack, competing request ignored
    @(negedge clk);
    addr = 24'h400010; word = 1'b1; write = 1'b1; wdata = 16'hA1B2;
    bus16 = 1'b1; irom = 1'b1; iram = 1'b1; sc = 1'b0; req = 1'b1;
    @(negedge clk);
    addr = 24'h500020; wdata = 16'h0000; req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9", "held addr", ext_addr, 24'h400010);
      chk("R9", "held dout", dout, 16'hA1B2);
      chk("R9", "held strobes", strobes(), 4'b0100);
    end
    req = 1'b0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9", "done after ack", done, 1);
    @(negedge clk);
    chk("R9", "done single pulse", done, 0);
    chk("R9", "no restart", busy, 0);

    // R5: narrow word read reassembly with different byte values
    run_vec('{24'h600004, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0,
              16'hDE01, 16'hAD02, 2'd1, 4'b0011, 16'h0000, 16'h0000, 16'hDEAD});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule